// File: doc/BRIEF.md
# Selective DCT Coefficient Scrambler

This block hides the content of an image in the frequency domain. It takes a stream of 2-D DCT coefficients, one 8x8 block of a single colour component at a time. Each coefficient arrives with a valid strobe and its position in the block, 0 to 63. Only the DC term and a programmable set of AC positions are masked. Each masked coefficient has a pseudo-random word added to it, modulo the coefficient width. All other coefficients leave the block exactly as they came in. The stream leaves the block one cycle later, with the same valid pattern and the same positions.

The pseudo-random words come from a 16-bit maximal-length linear feedback shift register. The register steps only when a masked coefficient is accepted. Both ends therefore stay in step, provided they use the same selection mask and the same seed. A decrypt input changes the addition into a subtraction, so the same block restores the plaintext coefficients. A seed-load pulse restarts the sequence from a chosen value. An all-zero seed is replaced by a fixed nonzero word.

Top module: `dct_coef_scrambler`

## Requirements
- R1: After synchronous reset, out_valid, out_idx and out_coef are 0, and the generator state is 16'hACE1. The first masked coefficient after reset therefore receives the low COEF_W bits of 16'hACE1.
- R2: out_valid equals in_valid one cycle earlier. out_idx equals in_idx one cycle earlier whenever out_valid is 1.
- R3: A coefficient at position 0 (DC) is always masked, whatever the value of sel_mask bit 0.
- R4: An AC coefficient at position i (1..63) is masked when sel_mask[i] is 1. Otherwise it appears on out_coef unchanged, and the generator state does not move.
- R5: The generator is a Fibonacci register of 16 bits, s[15:0]. On each step it shifts left, and the new bit 0 is s[15]^s[14]^s[12]^s[3]. It steps once for each masked coefficient that is accepted, and its state is never zero. The key word used for a coefficient is s[COEF_W-1:0], taken before that coefficient's step.
- R6: With decrypt at 0, a masked coefficient leaves as (in_coef + key) mod 2^COEF_W.
- R7: With decrypt at 1, a masked coefficient leaves as (in_coef - key) mod 2^COEF_W. Decrypting the output stream with the same seed and mask restores the original coefficients exactly.
- R8: When seed_load is 1, the next generator state is seed_val, or 16'hACE1 if seed_val is zero. A coefficient accepted in the same cycle uses the old state, and no step happens in that cycle.
- R9: While in_valid is 0, out_coef and out_idx keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Loads seed_val into the generator |
| seed_val | input | 16 | Seed word (zero is replaced by 16'hACE1) |
| sel_mask | input | 64 | AC positions to mask, one bit per position |
| decrypt | input | 1 | 0 adds the key word, 1 subtracts it |
| in_valid | input | 1 | Input coefficient valid |
| in_idx | input | 6 | Position of the input coefficient in the 8x8 block |
| in_coef | input | COEF_W | Input coefficient, two's complement |
| out_valid | output | 1 | Output coefficient valid |
| out_idx | output | 6 | Position of the output coefficient |
| out_coef | output | COEF_W | Scrambled or restored coefficient |

## Verification
The assertions assume that reset is held for at least one clock edge before any traffic. They also assume that seed_val, sel_mask and decrypt are stable, valid values in every cycle, including cycles where in_valid is low, because the properties sample them on every edge. The bench drives every input on the falling edge from a defined value and holds it for the whole cycle. Random traffic draws positions, coefficients, masks and the decrypt mode from a fixed-seed generator. Seed loads come either as isolated pulses or together with a coefficient, so the R8 same-cycle ordering is covered.

// File: rtl/dct_scr_pkg.sv
package dct_scr_pkg;

    localparam int          BLK_N         = 64;
    localparam int          IDX_W         = $clog2(BLK_N);
    localparam int          KEY_REG_W     = 16;
    localparam logic [15:0] SEED_FALLBACK = 16'hACE1;

    typedef enum logic {
        MIX_ADD = 1'b0,
        MIX_SUB = 1'b1
    } mix_op_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic             selected;
        mix_op_e          op;
    } coef_tag_t;

    function automatic logic [KEY_REG_W-1:0] key_step(input logic [KEY_REG_W-1:0] s);
        return {s[KEY_REG_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    function automatic logic [KEY_REG_W-1:0] seed_fix(input logic [KEY_REG_W-1:0] s);
        return (s == '0) ? SEED_FALLBACK : s;
    endfunction

endpackage

// File: rtl/scr_keygen.sv
module scr_keygen
    import dct_scr_pkg::*;
#(
    parameter int COEF_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seed_load,
    input  logic [KEY_REG_W-1:0] seed_val,
    input  logic                 advance,
    output logic [KEY_REG_W-1:0] state,
    output logic [COEF_W-1:0]    key
);

    logic [KEY_REG_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_FALLBACK;
        end else if (seed_load) begin
            state_q <= seed_fix(seed_val);
        end else if (advance) begin
            state_q <= key_step(state_q);
        end
    end

    assign state = state_q;
    assign key   = state_q[COEF_W-1:0];

endmodule

// File: rtl/scr_select.sv
module scr_select
    import dct_scr_pkg::*;
(
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [BLK_N-1:0] sel_mask,
    input  logic             decrypt,
    output coef_tag_t        tag
);

    logic [BLK_N-1:0] pos_sel;

    for (genvar p = 0; p < BLK_N; p++) begin : g_pos
        if (p == 0) begin : g_dc
            assign pos_sel[p] = 1'b1;
        end else begin : g_ac
            assign pos_sel[p] = sel_mask[p];
        end
    end

    always_comb begin
        tag.valid    = in_valid;
        tag.idx      = in_idx;
        tag.selected = pos_sel[in_idx];
        tag.op       = decrypt ? MIX_SUB : MIX_ADD;
    end

endmodule

// File: rtl/scr_mix.sv
module scr_mix
    import dct_scr_pkg::*;
#(
    parameter int COEF_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  coef_tag_t        tag,
    input  logic [COEF_W-1:0] in_coef,
    input  logic [COEF_W-1:0] key,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [COEF_W-1:0] out_coef
);

    logic [COEF_W-1:0] mixed;

    always_comb begin
        if (!tag.selected) begin
            mixed = in_coef;
        end else if (tag.op == MIX_SUB) begin
            mixed = in_coef - key;
        end else begin
            mixed = in_coef + key;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_coef  <= '0;
        end else begin
            out_valid <= tag.valid;
            if (tag.valid) begin
                out_idx  <= tag.idx;
                out_coef <= mixed;
            end
        end
    end

endmodule

// File: rtl/dct_coef_scrambler.sv
module dct_coef_scrambler
    import dct_scr_pkg::*;
#(
    parameter int COEF_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [15:0]       seed_val,
    input  logic [63:0]       sel_mask,
    input  logic              decrypt,
    input  logic              in_valid,
    input  logic [5:0]        in_idx,
    input  logic [COEF_W-1:0] in_coef,
    output logic              out_valid,
    output logic [5:0]        out_idx,
    output logic [COEF_W-1:0] out_coef
);

    coef_tag_t            tag;
    logic [KEY_REG_W-1:0] key_state;
    logic [COEF_W-1:0]    key;
    logic                 step_en;

    scr_select u_sel (
        .in_valid (in_valid),
        .in_idx   (in_idx),
        .sel_mask (sel_mask),
        .decrypt  (decrypt),
        .tag      (tag)
    );

    assign step_en = tag.valid & tag.selected;

    scr_keygen #(.COEF_W(COEF_W)) u_key (
        .clk       (clk),
        .rst       (rst),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .advance   (step_en),
        .state     (key_state),
        .key       (key)
    );

    scr_mix #(.COEF_W(COEF_W)) u_mix (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .in_coef   (in_coef),
        .key       (key),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_coef  (out_coef)
    );

endmodule

// File: rtl/dct_scr_checker.sv
module dct_scr_checker #(
    parameter int COEF_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              seed_load,
    input logic [15:0]       seed_val,
    input logic [63:0]       sel_mask,
    input logic              in_valid,
    input logic [5:0]        in_idx,
    input logic [COEF_W-1:0] in_coef,
    input logic              out_valid,
    input logic [5:0]        out_idx,
    input logic [COEF_W-1:0] out_coef,
    input logic [15:0]       key_state
);

    logic ac_plain;
    assign ac_plain = in_valid && (in_idx != 6'd0) && !sel_mask[in_idx];

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idx_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_idx == $past(in_idx)));

    assert_dc_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_idx == 6'd0 && !seed_load) |=> (key_state != $past(key_state)));

    assert_plain_passes_R4: assert property (@(posedge clk) disable iff (rst)
        ac_plain |=> (out_coef == $past(in_coef)));

    assert_plain_no_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !(in_valid && (in_idx == 6'd0 || sel_mask[in_idx]))) |=> $stable(key_state));

    assert_state_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        key_state != 16'd0);

    assert_seed_load_R8: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_val != 16'd0) |=> (key_state == $past(seed_val)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_coef) && $stable(out_idx)));

endmodule

bind dct_coef_scrambler dct_scr_checker #(.COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .sel_mask  (sel_mask),
    .in_valid  (in_valid),
    .in_idx    (in_idx),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_coef  (out_coef),
    .key_state (key_state)
);

// File: tb/dct_coef_scrambler_tb.sv
module dct_coef_scrambler_tb;

    localparam int W = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seed_load = 1'b0;
    logic [15:0]   seed_val = '0;
    logic [63:0]   sel_mask = '0;
    logic          decrypt = 1'b0;
    logic          in_valid = 1'b0;
    logic [5:0]    in_idx = '0;
    logic [W-1:0]  in_coef = '0;
    logic          out_valid;
    logic [5:0]    out_idx;
    logic [W-1:0]  out_coef;

    always #4 clk = ~clk;

    dct_coef_scrambler #(.COEF_W(W)) u_dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
        .sel_mask(sel_mask), .decrypt(decrypt), .in_valid(in_valid),
        .in_idx(in_idx), .in_coef(in_coef), .out_valid(out_valid),
        .out_idx(out_idx), .out_coef(out_coef)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [15:0]  m_state;
    logic         e_valid;
    logic [5:0]   e_idx;
    logic [W-1:0] e_coef;
    string        e_tag;
    bit           have_exp;

    logic [W-1:0] plain [64];
    logic [W-1:0] cipher [64];

    function automatic logic [15:0] ref_step(input logic [15:0] s);
        logic fb;
        fb = s[15] ^ s[14] ^ s[12] ^ s[3];
        return {s[14:0], fb};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_outputs();
        if (!have_exp) return;
        chk({e_tag, " valid (R2)"}, {31'd0, out_valid}, {31'd0, e_valid});
        if (e_valid) begin
            chk({e_tag, " idx (R2)"}, {26'd0, out_idx}, {26'd0, e_idx});
            chk({e_tag, " coef"}, {20'd0, out_coef}, {20'd0, e_coef});
        end else begin
            chk("R9 hold coef", {20'd0, out_coef}, {20'd0, e_coef});
            chk("R9 hold idx", {26'd0, out_idx}, {26'd0, e_idx});
        end
    endtask

    task automatic cyc(input bit v, input logic [5:0] idx, input logic [W-1:0] c,
                       input bit dec, input bit sl, input logic [15:0] sv,
                       input logic [63:0] mask, input string tag);
        bit sel;
        @(negedge clk);
        compare_outputs();
        in_valid = v; in_idx = idx; in_coef = c; decrypt = dec;
        seed_load = sl; seed_val = sv; sel_mask = mask;
        sel = (idx == 6'd0) || mask[idx];
        e_valid = v;
        if (v) begin
            e_idx = idx;
            if (!sel) e_coef = c;
            else if (dec) e_coef = c - m_state[W-1:0];
            else e_coef = c + m_state[W-1:0];
        end
        if (sl) m_state = (sv == 16'd0) ? 16'hACE1 : sv;
        else if (v && sel) m_state = ref_step(m_state);
        e_tag = tag;
        have_exp = 1;
    endtask

    task automatic idle(input string tag);
        cyc(0, 6'd0, '0, 0, 0, 16'd0, 64'd0, tag);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [63:0] rmask;
        logic [15:0] lfsr_walk;
        void'($urandom(32'd2024));
        m_state = 16'hACE1;
        e_valid = 0; e_idx = '0; e_coef = '0; e_tag = "R1"; have_exp = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values on the ports
        @(negedge clk);
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 out_idx", {26'd0, out_idx}, 32'd0);
        chk("R1 out_coef", {20'd0, out_coef}, 32'd0);
        have_exp = 1; e_tag = "R1";
        // R1: first DC gets the low bits of 16'hACE1
        cyc(1, 6'd0, 12'd0, 0, 0, 16'd0, 64'd0, "R1 reset key R3");
        @(negedge clk);
        chk("R1 first key", {20'd0, out_coef}, 32'h0CE1);
        have_exp = 0;
        in_valid = 0;
        @(negedge clk);
        have_exp = 1; e_valid = 0;
        // R3: DC masked even when mask bit 0 is clear or set
        cyc(1, 6'd0, 12'h100, 0, 0, 16'd0, 64'd0, "R3 dc mask0");
        cyc(1, 6'd0, 12'h100, 0, 0, 16'd0, 64'd1, "R3 dc mask1");
        // R4: unselected AC passes, state untouched
        cyc(1, 6'd5, 12'h7FF, 0, 0, 16'd0, 64'd0, "R4 pass");
        cyc(1, 6'd63, 12'h800, 0, 0, 16'd0, 64'd0, "R4 pass edge");
        cyc(1, 6'd63, 12'h800, 0, 0, 16'd0, 64'h8000_0000_0000_0000, "R4 sel63");
        // R6: wrap modulo 2^W
        cyc(0, 6'd0, '0, 0, 1, 16'h0FFF, 64'd0, "R8 load");
        cyc(1, 6'd0, 12'hFFF, 0, 0, 16'd0, 64'd0, "R6 wrap");
        // R8: zero seed replaced by fallback
        cyc(0, 6'd0, '0, 0, 1, 16'd0, 64'd0, "R8 zero seed");
        cyc(1, 6'd0, 12'd0, 0, 0, 16'd0, 64'd0, "R8 fallback key");
        @(negedge clk);
        compare_outputs();
        chk("R8 fallback value", {20'd0, out_coef}, 32'h0CE1);
        have_exp = 0; in_valid = 0;
        @(negedge clk);
        have_exp = 1; e_valid = 0;
        // R8: load with coefficient in same cycle uses old state
        cyc(1, 6'd0, 12'd0, 0, 1, 16'h1234, 64'd0, "R8 same cycle");
        cyc(1, 6'd0, 12'd0, 0, 0, 16'd0, 64'd0, "R8 new seed");
        @(negedge clk);
        compare_outputs();
        chk("R8 new seed value", {20'd0, out_coef}, 32'h0234);
        have_exp = 0; in_valid = 0;
        @(negedge clk);
        have_exp = 1; e_valid = 0;
        // R5: walk the generator and compare key words with a stepped reference
        lfsr_walk = 16'h0001;
        cyc(0, 6'd0, '0, 0, 1, 16'h0001, 64'd0, "R5 load");
        for (int k = 0; k < 40; k++) begin
            cyc(1, 6'd0, 12'd0, 0, 0, 16'd0, 64'd0, "R5 walk");
            @(negedge clk);
            compare_outputs();
            chk("R5 walk key", {20'd0, out_coef}, {20'd0, lfsr_walk[W-1:0]});
            lfsr_walk = ref_step(lfsr_walk);
            have_exp = 0; in_valid = 0;
            @(negedge clk);
            have_exp = 1; e_valid = 0;
        end
        // R7: encrypt a block then decrypt with the same seed and mask
        rmask = {$urandom, $urandom};
        for (int k = 0; k < 64; k++) plain[k] = W'($urandom);
        cyc(0, 6'd0, '0, 0, 1, 16'hBEEF, rmask, "R8 load enc");
        for (int k = 0; k < 64; k++) begin
            cyc(1, 6'(k), plain[k], 0, 0, 16'd0, rmask, "R6 enc block");
            cipher[k] = e_coef;
        end
        cyc(0, 6'd0, '0, 1, 1, 16'hBEEF, rmask, "R8 load dec");
        for (int k = 0; k < 64; k++) begin
            cyc(1, 6'(k), cipher[k], 1, 0, 16'd0, rmask, "R7 dec block");
            @(negedge clk);
            compare_outputs();
            chk("R7 round trip", {20'd0, out_coef}, {20'd0, plain[k]});
            have_exp = 0; in_valid = 0;
            @(negedge clk);
            have_exp = 1; e_valid = 0;
        end
        // random traffic across R2/R4/R6/R7/R8/R9
        for (int k = 0; k < 3000; k++) begin
            bit v, sl, dec;
            v   = ($urandom % 4) != 0;
            sl  = ($urandom % 50) == 0;
            dec = $urandom % 2;
            if (k % 200 == 0) rmask = {$urandom, $urandom};
            cyc(v, 6'($urandom), W'($urandom), dec, sl, 16'($urandom % 8 == 0 ? 0 : $urandom),
                rmask, "R4 R6 random");
        end
        idle("R9 tail");
        idle("R9 tail");
        @(negedge clk);
        compare_outputs();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule